// File: doc/BRIEF.md
# Hybrid-Precision Activation Splitter

This block sorts a stream of signed 16-bit fixed-point activations into two output streams by magnitude. A value whose magnitude does not exceed a programmable threshold is an inlier. It is scaled by a shift derived from the threshold's leading-one position, rounded, and sent as a signed 8-bit word on a dense stream. A value above the threshold is an outlier. It is encoded as an 8-bit float (1 sign, 4 exponent, 3 mantissa bits) and sent on a sparse stream together with its position in the current tile row. The dense stream still carries one word for that outlier, marked as a skip and holding zero. The dense stream therefore keeps exactly one entry per input, and a consumer recovers an approximation of the original value by adding the scaled dense word to the float at the same index.

A configuration write loads the threshold and the index of the last element in a row. The dense shift is computed from the threshold when the write happens. Input and both outputs use valid/ready handshakes. Each output has one register slot. The input is accepted only when both slots can take a new element.

Top module: `hp_act_splitter`

## Requirements
- R1: After reset both output valids are low and `in_ready` is high. The threshold is 255, the last row index is 255 and the row position is 0.
- R2: An accepted value with |x| greater than the threshold is an outlier. It produces a dense word 0 with `dn_skip`=1 and one sparse output. A value with |x| equal to or below the threshold produces a dense word with `dn_skip`=0 and no sparse output.
- R3: An inlier is coded as follows. Let p be the index of the threshold's highest set bit (p=0 for a threshold of 0) and s = max(0, p-7). When s>0 the dense word is floor((x + 2^(s-1)) / 2^s); when s=0 it is x. The result is clamped to [-128, 127] and given in two's complement.
- R4: The sparse word has the sign in bit 7, the exponent e in bits 6:3 and the mantissa m in bits 2:0, so that |x| ≈ (1 + m/8)·2^e. Rounding is to nearest with ties to even. A mantissa carry increments e, and e above 15 saturates to e=15, m=7.
- R5: `sp_idx` is the position of the outlier within its row, counted from 0 over all accepted elements. The position returns to 0 after the element at the configured last index.
- R6: While `cfg_wr` is high, `in_ready` is low. The write loads the threshold and the last index and resets the row position to 0. Elements accepted afterwards use the new values.
- R7: `in_ready` is high exactly when `cfg_wr` is low and each output either is not valid or has ready high. An output held by a low ready keeps its valid and data unchanged.
- R8: Both streams deliver elements in acceptance order. An element accepted at a clock edge is presented on its outputs from that edge onward.
- R9: Every accepted element produces exactly one dense output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_thresh | input | 16 | Inlier magnitude threshold |
| cfg_row_last | input | 8 | Index of the last element in a row |
| in_valid | input | 1 | Input element offered |
| in_ready | output | 1 | Input element accepted when valid |
| in_data | input | 16 | Signed fixed-point activation |
| dn_valid | output | 1 | Dense word available |
| dn_ready | input | 1 | Dense consumer takes the word |
| dn_data | output | 8 | Signed scaled inlier or zero |
| dn_skip | output | 1 | Slot belongs to an outlier |
| sp_valid | output | 1 | Sparse word available |
| sp_ready | input | 1 | Sparse consumer takes the word |
| sp_data | output | 8 | Float-coded outlier |
| sp_idx | output | 8 | Row position of the outlier |

## Verification
Two things can happen in the same cycle: a configuration write, and an element offered on the input while a previously accepted outlier is still stalled on the sparse output. The bench provokes this by raising `cfg_wr` with `in_valid` high under random back-pressure on both outputs. It then checks that the offered element is not taken in that cycle. Next it checks that the element is later accepted with the new threshold and with row position 0, and that the stalled outlier leaves unchanged with its old index. A behavioural model with queues predicts every dense and sparse word and compares them on each transfer.

// File: rtl/hps_pkg.sv
package hps_pkg;

   // Index of the highest set bit; 0 when no bit is set.
   function automatic int lead_one(input logic [31:0] v);
      int p;
      p = 0;
      for (int i = 0; i < 32; i++) begin
         if (v[i]) p = i;
      end
      return p;
   endfunction

   // Right shift that maps the range up to the threshold onto dense_w signed bits.
   function automatic int dense_shift(input logic [31:0] thr, input int dense_w);
      int p;
      p = lead_one(thr);
      return (p > dense_w - 1) ? p - (dense_w - 1) : 0;
   endfunction

endpackage

// File: rtl/hps_cfg_reg.sv
module hps_cfg_reg #(
   parameter int DATA_W       = 16,
   parameter int DENSE_W      = 8,
   parameter int IDX_W        = 8,
   parameter int SH_W         = 4,
   parameter int RST_THRESH   = 255,
   parameter int RST_ROW_LAST = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] thr_in,
   input  logic [IDX_W-1:0]  last_in,
   output logic [DATA_W-1:0] thr_q,
   output logic [IDX_W-1:0]  last_q,
   output logic [SH_W-1:0]   shift_q
);
   localparam int RST_SHIFT = hps_pkg::dense_shift(32'(RST_THRESH), DENSE_W);

   logic [SH_W-1:0] shift_d;

   always_comb begin
      shift_d = SH_W'(hps_pkg::dense_shift(32'(thr_in), DENSE_W));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q   <= DATA_W'(RST_THRESH);
         last_q  <= IDX_W'(RST_ROW_LAST);
         shift_q <= SH_W'(RST_SHIFT);
      end else if (wr) begin
         thr_q   <= thr_in;
         last_q  <= last_in;
         shift_q <= shift_d;
      end
   end
endmodule

// File: rtl/hps_row_idx.sv
module hps_row_idx #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   input  logic [IDX_W-1:0] last,
   output logic [IDX_W-1:0] idx_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         idx_q <= '0;
      end else if (adv) begin
         if (idx_q == last) idx_q <= '0;
         else               idx_q <= idx_q + IDX_W'(1);
      end
   end
endmodule

// File: rtl/hps_dense_quant.sv
module hps_dense_quant #(
   parameter int DATA_W        = 16,
   parameter int DENSE_W       = 8,
   parameter int SH_W          = 4,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic [DATA_W-1:0]  x,
   input  logic [SH_W-1:0]    shift,
   output logic [DENSE_W-1:0] q
);
   localparam int EXT_W = DATA_W + 1;
   localparam logic signed [EXT_W-1:0] QMAX = EXT_W'((2 ** (DENSE_W - 1)) - 1);
   localparam logic signed [EXT_W-1:0] QMIN = -QMAX - EXT_W'(1);

   logic signed [EXT_W-1:0] xs;
   logic signed [EXT_W-1:0] scaled;

   always_comb begin
      xs = $signed({x[DATA_W-1], x});
   end

   generate
      if (ROUND_NEAREST) begin : g_round
         logic signed [EXT_W-1:0] half;
         always_comb begin
            if (shift == '0) half = '0;
            else             half = EXT_W'(1) << (shift - SH_W'(1));
            scaled = (xs + half) >>> shift;
         end
      end else begin : g_trunc
         always_comb begin
            scaled = xs >>> shift;
         end
      end
   endgenerate

   always_comb begin
      if (scaled > QMAX)      q = QMAX[DENSE_W-1:0];
      else if (scaled < QMIN) q = QMIN[DENSE_W-1:0];
      else                    q = scaled[DENSE_W-1:0];
   end
endmodule

// File: rtl/hps_fp8_enc.sv
module hps_fp8_enc #(
   parameter int DATA_W   = 16,
   parameter int EXP_W    = 4,
   parameter int MAN_W    = 3,
   parameter int EXP_BIAS = 0
) (
   input  logic [DATA_W-1:0]          x,
   output logic [EXP_W+MAN_W:0]       code
);
   localparam int EMAX = (2 ** EXP_W) - 1;
   localparam int FR_W = DATA_W - 1;

   logic [DATA_W-1:0] mag;
   logic [FR_W-1:0]   frac;
   logic [MAN_W-1:0]  mant;
   logic [MAN_W:0]    mant_r;
   logic              guard;
   logic              sticky;
   logic [EXP_W-1:0]  exp_fld;
   logic [MAN_W-1:0]  man_fld;
   int                p;
   int                e_full;

   always_comb begin
      mag = x[DATA_W-1] ? (~x + DATA_W'(1)) : x;
      p = 0;
      for (int i = 0; i < DATA_W; i++) begin
         if (mag[i]) p = i;
      end
      // bits below the leading one, left aligned; the leading one is dropped
      frac   = FR_W'(mag << (DATA_W - 1 - p));
      mant   = frac[FR_W-1 -: MAN_W];
      guard  = frac[FR_W-1-MAN_W];
      sticky = |frac[FR_W-2-MAN_W:0];
      mant_r = {1'b0, mant} + (MAN_W+1)'(guard & (sticky | mant[0]));
      e_full = p + EXP_BIAS + int'(mant_r[MAN_W]);
      if (e_full > EMAX) begin
         exp_fld = EXP_W'(EMAX);
         man_fld = '1;
      end else begin
         exp_fld = EXP_W'(e_full);
         man_fld = mant_r[MAN_W-1:0];
      end
      code = {x[DATA_W-1], exp_fld, man_fld};
   end
endmodule

// File: rtl/hp_act_splitter.sv
module hp_act_splitter #(
   parameter int DATA_W        = 16,
   parameter int DENSE_W       = 8,
   parameter int EXP_W         = 4,
   parameter int MAN_W         = 3,
   parameter int EXP_BIAS      = 0,
   parameter int IDX_W         = 8,
   parameter bit ROUND_NEAREST = 1'b1,
   parameter int RST_THRESH    = 255,
   parameter int RST_ROW_LAST  = 255
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [DATA_W-1:0]      cfg_thresh,
   input  logic [IDX_W-1:0]       cfg_row_last,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [DATA_W-1:0]      in_data,
   output logic                   dn_valid,
   input  logic                   dn_ready,
   output logic [DENSE_W-1:0]     dn_data,
   output logic                   dn_skip,
   output logic                   sp_valid,
   input  logic                   sp_ready,
   output logic [EXP_W+MAN_W:0]   sp_data,
   output logic [IDX_W-1:0]       sp_idx
);
   localparam int SH_W = $clog2(DATA_W) + 1;
   localparam int FP_W = 1 + EXP_W + MAN_W;

   generate
      if (DENSE_W < 2 || DENSE_W > DATA_W) begin : g_bad_dense
         $error("DENSE_W must lie in 2..DATA_W");
      end
      if (DATA_W < MAN_W + 3) begin : g_bad_man
         $error("DATA_W must exceed MAN_W by at least 3");
      end
      if (EXP_W < 2 || MAN_W < 1 || IDX_W < 1) begin : g_bad_fp
         $error("float and index widths too small");
      end
      if (RST_THRESH < 0 || RST_THRESH >= 2 ** (DATA_W - 1)) begin : g_bad_rst
         $error("RST_THRESH out of range");
      end
   endgenerate

   logic [DATA_W-1:0]  thr_q;
   logic [IDX_W-1:0]   last_q;
   logic [IDX_W-1:0]   idx_q;
   logic [SH_W-1:0]    shift_q;
   logic [DATA_W-1:0]  mag;
   logic               outlier;
   logic               accept;
   logic [DENSE_W-1:0] q_val;
   logic [FP_W-1:0]    f_val;

   hps_cfg_reg #(
      .DATA_W(DATA_W), .DENSE_W(DENSE_W), .IDX_W(IDX_W), .SH_W(SH_W),
      .RST_THRESH(RST_THRESH), .RST_ROW_LAST(RST_ROW_LAST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
      .thr_in(cfg_thresh), .last_in(cfg_row_last),
      .thr_q(thr_q), .last_q(last_q), .shift_q(shift_q)
   );

   hps_row_idx #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .adv(accept),
      .last(last_q), .idx_q(idx_q)
   );

   hps_dense_quant #(
      .DATA_W(DATA_W), .DENSE_W(DENSE_W), .SH_W(SH_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_quant (
      .x(in_data), .shift(shift_q), .q(q_val)
   );

   hps_fp8_enc #(
      .DATA_W(DATA_W), .EXP_W(EXP_W), .MAN_W(MAN_W), .EXP_BIAS(EXP_BIAS)
   ) u_enc (
      .x(in_data), .code(f_val)
   );

   always_comb begin
      in_ready = !cfg_wr && (!dn_valid || dn_ready) && (!sp_valid || sp_ready);
      accept   = in_valid && in_ready;
      mag      = in_data[DATA_W-1] ? (~in_data + DATA_W'(1)) : in_data;
      outlier  = mag > thr_q;
   end

   // dense slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         dn_data  <= '0;
         dn_skip  <= 1'b0;
      end else if (accept) begin
         dn_valid <= 1'b1;
         dn_data  <= outlier ? '0 : q_val;
         dn_skip  <= outlier;
      end else if (dn_ready) begin
         dn_valid <= 1'b0;
      end
   end

   // sparse slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_valid <= 1'b0;
         sp_data  <= '0;
         sp_idx   <= '0;
      end else if (accept && outlier) begin
         sp_valid <= 1'b1;
         sp_data  <= f_val;
         sp_idx   <= idx_q;
      end else if (sp_ready) begin
         sp_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/hp_act_splitter_chk.sv
module hp_act_splitter_chk #(
   parameter int DENSE_W = 8,
   parameter int FP_W    = 8,
   parameter int IDX_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_wr,
   input logic               in_valid,
   input logic               in_ready,
   input logic               dn_valid,
   input logic               dn_ready,
   input logic [DENSE_W-1:0] dn_data,
   input logic               dn_skip,
   input logic               sp_valid,
   input logic               sp_ready,
   input logic [FP_W-1:0]    sp_data,
   input logic [IDX_W-1:0]   sp_idx
);
   // R6
   cfg_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |-> !in_ready);

   // R7
   dense_stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |-> !in_ready);

   // R7
   dense_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_skip)));

   // R7
   sparse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_valid && !sp_ready) |=> (sp_valid && $stable(sp_data) && $stable(sp_idx)));

   // R9
   dense_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> dn_valid);

   // R2
   sparse_iff_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (sp_valid == dn_skip));

   // R2
   skip_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_skip) |-> (dn_data == '0));
endmodule

bind hp_act_splitter hp_act_splitter_chk #(
   .DENSE_W(DENSE_W), .FP_W(1 + EXP_W + MAN_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .in_valid(in_valid), .in_ready(in_ready),
   .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data), .dn_skip(dn_skip),
   .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_data(sp_data), .sp_idx(sp_idx)
);

// File: tb/hp_act_splitter_test.sv
module hp_act_splitter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_thresh = '0;
   logic [7:0]  cfg_row_last = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        dn_valid;
   logic        dn_ready = 1'b0;
   logic [7:0]  dn_data;
   logic        dn_skip;
   logic        sp_valid;
   logic        sp_ready = 1'b0;
   logic [7:0]  sp_data;
   logic [7:0]  sp_idx;

   int checks = 0;
   int errors = 0;
   int bp = 0;
   int m_thr = 255;
   int m_last = 255;
   int m_idx = 0;
   bit prev_acc = 0;
   logic [8:0]  dq[$];
   logic [15:0] sq[$];

   always #10 clk = ~clk;

   hp_act_splitter uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_thresh(cfg_thresh),
      .cfg_row_last(cfg_row_last), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
      .dn_skip(dn_skip), .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_data(sp_data),
      .sp_idx(sp_idx)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int msb_of(input int v);
      int p = 0;
      while (v > 1) begin v = v / 2; p++; end
      return p;
   endfunction

   function automatic logic [7:0] ref_dense(input int x, input int thr);
      int p = msb_of(thr);
      int s = (p > 7) ? p - 7 : 0;
      int q = x;
      if (s > 0) q = (x + (1 << (s - 1))) >>> s;
      if (q > 127) q = 127;
      if (q < -128) q = -128;
      return q[7:0];
   endfunction

   function automatic logic [7:0] ref_fp8(input int x);
      int mag = (x < 0) ? -x : x;
      int p = msb_of(mag);
      int fr = mag - (1 << p);
      int m, e, dv, rem;
      if (p <= 3) m = fr << (3 - p);
      else begin
         dv = 1 << (p - 3);
         m = fr / dv;
         rem = fr % dv;
         if (rem > dv / 2 || (rem == dv / 2 && (m % 2) == 1)) m++;
      end
      e = p;
      if (m == 8) begin m = 0; e++; end
      if (e > 15) begin e = 15; m = 7; end
      return {(x < 0) ? 1'b1 : 1'b0, e[3:0], m[2:0]};
   endfunction

   task automatic cyc(input bit v, input logic [15:0] d, input bit w,
                      input int t, input int l, output bit acc);
      logic [8:0]  de;
      logic [15:0] se;
      bit er;
      @(negedge clk);
      in_valid = v; in_data = d; cfg_wr = w;
      cfg_thresh = t[15:0]; cfg_row_last = l[7:0];
      dn_ready = ($urandom_range(0, 99) >= bp);
      sp_ready = ($urandom_range(0, 99) >= bp);
      #1;
      if (prev_acc) check(dn_valid == 1'b1, "R9 dense after accept", dn_valid, 1);
      er = !w && (!dn_valid || dn_ready) && (!sp_valid || sp_ready);
      if (w) check(in_ready == 1'b0, "R6 ready during write", in_ready, 0);
      else   check(in_ready == er, "R7 in_ready", in_ready, er);
      if (dn_valid && dn_ready) begin
         if (dq.size() == 0) check(0, "R8 unexpected dense", 1, 0);
         else begin
            de = dq.pop_front();
            check(dn_skip == de[8], "R2 skip flag", dn_skip, de[8]);
            check(dn_data == de[7:0], "R3 dense word", dn_data, de[7:0]);
         end
      end
      if (sp_valid && sp_ready) begin
         if (sq.size() == 0) check(0, "R8 unexpected sparse", 1, 0);
         else begin
            se = sq.pop_front();
            check(sp_data == se[15:8], "R4 sparse word", sp_data, se[15:8]);
            check(sp_idx == se[7:0], "R5 sparse index", sp_idx, se[7:0]);
         end
      end
      acc = v && in_ready;
      prev_acc = acc;
      if (acc) begin
         int xi = int'($signed(d));
         int mg = (xi < 0) ? -xi : xi;
         if (mg > m_thr) begin
            dq.push_back(9'h100);
            se = {ref_fp8(xi), m_idx[7:0]};
            sq.push_back(se);
         end else begin
            dq.push_back({1'b0, ref_dense(xi, m_thr)});
         end
         m_idx = (m_idx == m_last) ? 0 : m_idx + 1;
      end
      if (w) begin m_thr = t; m_last = l; m_idx = 0; end
   endtask

   task automatic send(input logic [15:0] d);
      bit acc;
      do cyc(1, d, 0, 0, 0, acc); while (!acc);
   endtask

   task automatic write_cfg(input int t, input int l, input bit offer, input logic [15:0] d);
      bit acc;
      cyc(offer, d, 1, t, l, acc);
      check(acc == 0, "R6 no accept on write", acc, 0);
   endtask

   task automatic idle(input int n);
      bit acc;
      for (int i = 0; i < n; i++) cyc(0, 16'h0, 0, 0, 0, acc);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(dn_valid == 0, "R1 dense valid reset", dn_valid, 0);
      check(sp_valid == 0, "R1 sparse valid reset", sp_valid, 0);
      check(in_ready == 1, "R1 ready after reset", in_ready, 1);

      // R1 reset threshold 255 and R3 scale with shift 0
      bp = 0;
      send(16'd100); send(16'd255); send(-16'sd255); send(16'd256);
      send(-16'sd300); send(16'd304); send(16'd272); send(16'sd32767);
      send(16'h8000); send(16'd0); send(-16'sd1);
      idle(4);

      // R6 write while offering, R5 short rows, R3 shift 2
      bp = 40;
      send(16'd5000);
      write_cfg(1000, 4, 1, 16'd2000);
      send(16'd2000); send(16'd7); send(-16'sd6); send(16'd1000); send(16'd1001);
      send(-16'sd1001); send(16'd3); send(-16'sd4000); send(16'd4000); send(16'd999);
      idle(6);

      // threshold zero: every nonzero value becomes an outlier
      write_cfg(0, 2, 0, 16'd0);
      send(16'd0); send(16'd1); send(-16'sd1); send(16'd9); send(16'd0);
      idle(6);

      // random phase under back-pressure with config writes colliding
      for (int blk = 0; blk < 12; blk++) begin
         int t = (blk % 3 == 0) ? $urandom_range(0, 300) : $urandom_range(300, 32767);
         bp = (blk % 4) * 25;
         write_cfg(t, $urandom_range(0, 20), 1, 16'($urandom));
         for (int k = 0; k < 250; k++) begin
            logic [15:0] d;
            if ($urandom_range(0, 9) == 0) d = 16'($urandom);
            else begin
               int v = $urandom_range(0, 2 * t + 2);
               if ($urandom_range(0, 1) == 1) v = -v;
               d = 16'(v);
            end
            send(d);
         end
      end
      bp = 0;
      idle(10);
      check(dq.size() == 0, "R9 dense queue drained", dq.size(), 0);
      check(sq.size() == 0, "R8 sparse queue drained", sq.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule